// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a Five-Level Thermometer Stream

This block sits behind a single-channel delta-sigma modulator whose quantizer is built from four comparators with evenly spaced thresholds. On every clock it receives a 4-bit thermometer code, counts its ones, and maps the count to a signed level from -2 to +2. The levels pass through three cascaded integrators that run at the modulator rate. A decimation point is set by a selectable oversampling ratio of 32, 64, 128 or 256. Three differencing stages then run once per output word.

The filtered result is scaled by an arithmetic shift that depends on the ratio. Positive or negative full scale lands on the top of a 24-bit two's-complement word, with saturation instead of wraparound. In 16-bit mode the word is left justified in the same output bus and the lower byte reads zero. A one-cycle data-ready strobe marks each new word. The strobe is held back for the first three decimated outputs after a reset or a ratio change, while the filter memory fills.

Top module: `sinc3_decim`

## Requirements
- R1: The level of an input code is its number of ones minus two, whatever the order of the ones, so a bubbled code such as 4'b0101 counts as level 0 and 4'b1000 as level -1.
- R2: `osr_sel_i` values 0, 1, 2 and 3 select ratios of 32, 64, 128 and 256, and once settled a word is produced every ratio clocks.
- R3: For a constant level L held since reset, every settled 24-bit word equals L·2^22 for every ratio (L=+1 gives 0x400000, L=-1 gives 0xC00000, L=-2 gives 0x800000).
- R4: For an input that alternates between two levels on successive clocks, the settled word equals the mean level times 2^22 (for example 0x600000 for +2/+1 and 0x000000 for -2/+2).
- R5: With `wide_i`=1 the word uses all of `data_o[23:0]`. With `wide_i`=0 the 16-bit word sits in `data_o[23:8]` and `data_o[7:0]` is zero. A width change takes effect on the next word and does not restart the filter.
- R6: A result above the largest positive code saturates to 0x7FFFFF, which is 0x7FFF00 in 16-bit mode. A result below the most negative code saturates to 0x800000.
- R7: After reset the first three decimated outputs raise no strobe, so the first `drdy_o` comes no earlier than three ratio periods after reset release.
- R8: `drdy_o` is high for exactly one clock per word.
- R9: A change of `osr_sel_i` clears the filter: no strobe follows in the next clock or for three new ratio periods, and the first word after that is settled and correct.
- R10: `data_o` changes only in a clock where `drdy_o` is high.
- R11: While `rst_ni` is low, `data_o` is zero and `drdy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock, one input code per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| therm_i | input | 4 | Thermometer code from the quantizer |
| osr_sel_i | input | 2 | Oversampling ratio select (32·2^sel) |
| wide_i | input | 1 | 1: 24-bit word, 0: 16-bit word in the upper bits |
| data_o | output | 24 | Left-justified two's-complement output word |
| drdy_o | output | 1 | One-clock strobe for a new word |

## Verification
The bench drives full-scale positive input at a mid ratio. An implementation that wraps instead of saturating would return 0x800000 where 0x7FFFFF is due. The first strobe after reset and after a ratio change is timed. A design that shortened the hold-off would emit a strobe near two or three periods, and its word would still carry transient energy. Bubbled codes and alternating levels are applied. A decoder that used the highest set bit, or an integrator width that overflows at ratio 256, would miss the exact mean level. Switching between 16 and 24 bits mid-stream shows whether the low byte is cleared and whether the change wrongly restarts the filter, which would stretch the strobe period.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int THERM_W = 4;
  localparam int LVL_W   = 3;
  localparam int ORDER   = 3;

  // ones count minus mid level; bubble codes handled by counting
  function automatic logic signed [LVL_W-1:0] therm_to_level(input logic [THERM_W-1:0] t);
    logic [LVL_W-1:0] n;
    n = '0;
    for (int i = 0; i < THERM_W; i++) n = n + LVL_W'(t[i]);
    return signed'(n - LVL_W'(THERM_W / 2));
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ACC_W = 27,
  parameter int LVL_W = 3,
  parameter int ORDER = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic signed [LVL_W-1:0]      lvl_i,
  output logic        [ACC_W-1:0]      acc_o
);
  logic [ORDER-1:0][ACC_W-1:0] acc;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic [ACC_W-1:0] src;
    logic [ACC_W-1:0] acc_q;
    if (s == 0) begin : g_first
      assign src = {{(ACC_W-LVL_W){lvl_i[LVL_W-1]}}, lvl_i};
    end else begin : g_next
      assign src = acc[s-1];
    end
    // wraparound arithmetic is intended
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else            acc_q <= acc_q + src;
    end
    assign acc[s] = acc_q;
  end

  assign acc_o = acc[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ACC_W = 27,
  parameter int ORDER = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] x_i,
  output logic [ACC_W-1:0] y_o
);
  logic [ORDER:0][ACC_W-1:0] diff;
  assign diff[0] = x_i;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic [ACC_W-1:0] z_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     z_q <= '0;
      else if (clr_i)  z_q <= '0;
      else if (en_i)   z_q <= diff[s];
    end
    assign diff[s+1] = diff[s] - z_q;
  end

  assign y_o = diff[ORDER];
endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
  parameter int ACC_W    = 27,
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 5,
  parameter int OUT_W    = 24,
  parameter int NARROW_W = 16
) (
  input  logic [ACC_W-1:0] y_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wide_i,
  output logic [OUT_W-1:0] word_o
);
  // pre-shift so that the smallest ratio needs no left shift
  localparam int PRE   = OUT_W - 2 - 3 * MIN_LOG2;
  localparam int EXT_W = ACC_W + PRE;
  localparam int PAD_W = OUT_W - NARROW_W;
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'((64'sd1 <<< (OUT_W-1)) - 1);
  localparam logic signed [EXT_W-1:0] MIN_V = EXT_W'(-(64'sd1 <<< (OUT_W-1)));

  logic signed [EXT_W-1:0] ext, shv;
  logic        [OUT_W-1:0] sat;
  logic        [5:0]       sh;

  always_comb begin
    sh  = 6'(3 * sel_i);
    ext = {y_i, {PRE{1'b0}}};
    shv = ext >>> sh;
    if (shv > MAX_V)      sat = MAX_V[OUT_W-1:0];
    else if (shv < MIN_V) sat = MIN_V[OUT_W-1:0];
    else                  sat = shv[OUT_W-1:0];
    word_o = sat;
    if (!wide_i) word_o[PAD_W-1:0] = '0;
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 5,
  parameter int OUT_W    = 24,
  parameter int NARROW_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [THERM_W-1:0]   therm_i,
  input  logic [SEL_W-1:0]     osr_sel_i,
  input  logic                 wide_i,
  output logic [OUT_W-1:0]     data_o,
  output logic                 drdy_o
);
  localparam int MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1;
  localparam int ACC_W    = ORDER * MAX_LOG2 + 3;
  localparam int CNT_W    = MAX_LOG2;
  localparam int SET_W    = $clog2(ORDER + 1);

  logic [SEL_W-1:0]   osr_q;
  logic [CNT_W-1:0]   cnt_q, cnt_lim;
  logic [SET_W-1:0]   settle_q;
  logic               restart, strobe;
  logic signed [LVL_W-1:0] lvl;
  logic [ACC_W-1:0]   integ, comb;
  logic [OUT_W-1:0]   word;
  logic [OUT_W-1:0]   data_q;
  logic               drdy_q;

  assign restart = (osr_sel_i != osr_q);
  assign cnt_lim = CNT_W'((1 << (MIN_LOG2 + int'(osr_q))) - 1);
  assign strobe  = (cnt_q == cnt_lim);
  assign lvl     = therm_to_level(therm_i);

  sinc3_integ #(.ACC_W(ACC_W), .LVL_W(LVL_W), .ORDER(ORDER)) u_integ (
    .clk_i, .rst_ni, .clr_i(restart), .lvl_i(lvl), .acc_o(integ)
  );

  sinc3_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk_i, .rst_ni, .clr_i(restart), .en_i(strobe), .x_i(integ), .y_o(comb)
  );

  sinc3_scale #(
    .ACC_W(ACC_W), .SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2),
    .OUT_W(OUT_W), .NARROW_W(NARROW_W)
  ) u_scale (
    .y_i(comb), .sel_i(osr_q), .wide_i, .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osr_q    <= '0;
      cnt_q    <= '0;
      settle_q <= '0;
      drdy_q   <= 1'b0;
      data_q   <= '0;
    end else if (restart) begin
      osr_q    <= osr_sel_i;
      cnt_q    <= '0;
      settle_q <= '0;
      drdy_q   <= 1'b0;
    end else begin
      cnt_q  <= strobe ? '0 : cnt_q + 1'b1;
      drdy_q <= 1'b0;
      if (strobe) begin
        if (settle_q != SET_W'(ORDER)) begin
          settle_q <= settle_q + 1'b1;
        end else begin
          drdy_q <= 1'b1;
          data_q <= word;
        end
      end
    end
  end

  assign data_o = data_q;
  assign drdy_o = drdy_q;
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int SEL_W    = 2,
  parameter int OUT_W    = 24,
  parameter int NARROW_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] osr_sel_i,
  input logic             wide_i,
  input logic [OUT_W-1:0] data_o,
  input logic             drdy_o
);
  // R8
  drdy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o |=> !drdy_o);

  // R10
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_o |-> $stable(data_o));

  // R5
  narrow_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drdy_o && !$past(wide_i)) |-> (data_o[OUT_W-NARROW_W-1:0] == '0));

  // R9
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osr_sel_i != $past(osr_sel_i)) |=> !drdy_o);

  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!drdy_o && data_o == '0);
    end
  end
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .SEL_W(SEL_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .osr_sel_i(osr_sel_i),
  .wide_i(wide_i), .data_o(data_o), .drdy_o(drdy_o)
);

// File: tb/tb_sinc3_decim.sv
module tb_sinc3_decim;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 150000;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [3:0]  therm_i;
  logic [1:0]  osr_sel_i;
  logic        wide_i;
  logic [23:0] data_o;
  logic        drdy_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  int  cyc      = 0;
  bit  phase    = 1'b0;
  bit  done     = 1'b0;
  logic [3:0] pat_a, pat_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  sinc3_decim dut (
    .clk_i(clk), .rst_ni(rst_ni), .therm_i(therm_i),
    .osr_sel_i(osr_sel_i), .wide_i(wide_i), .data_o(data_o), .drdy_o(drdy_o)
  );

  task automatic tick();
    @(negedge clk);
    cyc++;
    phase   = ~phase;
    therm_i = phase ? pat_b : pat_a;
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_true(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_drdy(output int waited);
    waited = 0;
    do begin
      tick();
      waited++;
    end while (!drdy_o && waited < 4000);
  endtask

  function automatic int lvl(input logic [3:0] t);
    return $countones(t) - 2;
  endfunction

  function automatic logic [23:0] expect_word(input logic [3:0] a, input logic [3:0] b, input bit wide);
    longint v;
    logic [23:0] w;
    v = longint'(lvl(a) + lvl(b)) * 64'sd2097152;
    if (v > 64'sd8388607)  v = 64'sd8388607;
    if (v < -64'sd8388608) v = -64'sd8388608;
    w = v[23:0];
    if (!wide) w[7:0] = '0;
    return w;
  endfunction

  task automatic do_reset(input logic [1:0] osr, input bit wide, input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    rst_ni = 1'b0;
    osr_sel_i = osr; wide_i = wide; pat_a = a; pat_b = b; phase = 1'b0; therm_i = a;
    repeat (3) tick();
    check("R11 reset data", data_o, 24'h0);
    check("R11 reset drdy", {23'h0, drdy_o}, 24'h0);
    rst_ni = 1'b1;
  endtask

  // settle timing, period and value for one pattern
  task automatic t_stream(input string req, input logic [1:0] osr, input bit wide,
                          input logic [3:0] a, input logic [3:0] b);
    int w, r;
    r = 32 << osr;
    do_reset(osr, wide, a, b);
    wait_drdy(w);
    check_true("R7 first strobe delay", (w > 3*r) && (w <= 4*r + 2), w, 4*r);
    check({req, " first word"}, data_o, expect_word(a, b, wide));
    wait_drdy(w);
    check_true("R2 word period", w == r, w, r);
    check({req, " second word"}, data_o, expect_word(a, b, wide));
  endtask

  task automatic t_hold();
    logic [23:0] held;
    int w;
    do_reset(2'd0, 1'b1, 4'b0111, 4'b0111);
    wait_drdy(w);
    held = data_o;
    tick();
    check("R8 strobe one clock", {23'h0, drdy_o}, 24'h0);
    pat_a = 4'b0000; pat_b = 4'b0000;
    repeat (10) tick();
    check("R10 data held between strobes", data_o, held);
  endtask

  task automatic t_ratio_change();
    int w;
    do_reset(2'd0, 1'b1, 4'b0111, 4'b0111);
    repeat (5) wait_drdy(w);
    osr_sel_i = 2'd2;
    tick();
    check("R9 no strobe after change", {23'h0, drdy_o}, 24'h0);
    wait_drdy(w);
    check_true("R9 hold-off after change", w >= 3*128, w, 4*128);
    check("R9 word after change", data_o, 24'h400000);
    wait_drdy(w);
    check_true("R2 new period after change", w == 128, w, 128);
  endtask

  task automatic t_width_change();
    int w;
    do_reset(2'd1, 1'b1, 4'b1111, 4'b1111);
    wait_drdy(w);
    check("R6 full scale 24-bit", data_o, 24'h7FFFFF);
    wide_i = 1'b0;
    wait_drdy(w);
    check_true("R5 width change keeps period", w == 64, w, 64);
    check("R5 16-bit justified", data_o, 24'h7FFF00);
    wide_i = 1'b1;
    wait_drdy(w);
    check("R5 back to 24-bit", data_o, 24'h7FFFFF);
  endtask

  initial begin
    rst_ni = 1'b0; therm_i = '0; osr_sel_i = '0; wide_i = 1'b1;
    pat_a = '0; pat_b = '0;
    t_stream("R3 level -1 ratio 32",   2'd0, 1'b1, 4'b0001, 4'b0001);
    t_stream("R3 level +1 ratio 64",   2'd1, 1'b1, 4'b0111, 4'b0111);
    t_stream("R3 level -2 ratio 256",  2'd3, 1'b1, 4'b0000, 4'b0000);
    t_stream("R6 saturate ratio 128",  2'd2, 1'b1, 4'b1111, 4'b1111);
    t_stream("R6 saturate 16-bit",     2'd2, 1'b0, 4'b1111, 4'b1111);
    t_stream("R4 mean +1.5",           2'd0, 1'b1, 4'b1111, 4'b0111);
    t_stream("R4 mean zero",           2'd1, 1'b1, 4'b0000, 4'b1111);
    t_stream("R1 bubble codes",        2'd0, 1'b1, 4'b0101, 4'b1011);
    t_stream("R1 single-one bubble",   2'd0, 1'b0, 4'b1000, 4'b1000);
    t_hold();
    t_ratio_change();
    t_width_change();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule